// File: doc/BRIEF.md
# Tolerance Search Controller

This controller finds, at one stimulus frequency, the largest modulation amplitude that a device under test can take without producing more errors than allowed. It drives an amplitude code to an external modulator. For each trial it first waits a programmable settling interval so the device can recover, then opens an error-counting window of programmable length. At the end of the window it compares the error count against a threshold. The trial passes when the count does not exceed the threshold.

The search is a binary refinement. It starts at half of a supplied upper limit. After each trial the amplitude moves up on a pass and down on a fail, by half of the previous step. It ends when the step has shrunk to a programmable resolution. Configuration is captured when a search starts. At the end the controller reports the largest passing amplitude, or raises a separate flag when no trial passed.

Top module: `jtol_search`

## Requirements
- R1: After reset `amp_code`, `busy`, `done`, `no_pass` and `max_amp` are all zero.
- R2: A `start` sampled while idle or finished begins a search. One cycle later `busy` is high and `amp_code` equals floor(`tol_limit`/2). The first step size also equals floor(`tol_limit`/2).
- R3: After a trial with step s, the next amplitude is the current one plus floor(s/2) on a pass, or minus floor(s/2) on a fail, clamped to the range 0..2^AMP_W-1. The next step is floor(s/2).
- R4: The trial run with step s is the last one when s <= `resolution` or when floor(s/2) is zero.
- R5: Each trial keeps `busy` high for exactly `recover_len` + `gate_len` + 4 cycles: 1 setup cycle, `recover_len`+1 recovery cycles, `gate_len`+1 counting cycles and 1 decision cycle. `amp_code` is constant throughout the trial.
- R6: Error pulses are counted only during the counting cycles, and the count restarts from zero for every trial. Pulses during recovery have no effect on the outcome.
- R7: A trial fails when its error count is strictly greater than `err_limit`, and passes otherwise.
- R8: The error count saturates at 2^ERR_W-1 instead of wrapping.
- R9: When the search ends, `busy` falls and `done` rises and stays high until the next start. `max_amp` then holds the largest amplitude whose trial passed.
- R10: If no trial passed, `max_amp` is zero and `no_pass` is high together with `done`.
- R11: `start` has no effect while `busy` is high. The trial timing and the result are those of the search already running.
- R12: `amp_code` is zero whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (when not busy) |
| tol_limit | input | AMP_W | Upper amplitude limit; first trial is half of it |
| resolution | input | AMP_W | Finest step size that ends the search |
| recover_len | input | CNT_W | Recovery wait, in cycles (plus one) |
| gate_len | input | CNT_W | Counting window, in cycles (plus one) |
| err_limit | input | ERR_W | Largest error count that still passes |
| err_pulse | input | 1 | One error event per cycle it is high |
| amp_code | output | AMP_W | Amplitude code to the modulator |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, result valid |
| no_pass | output | 1 | Finished with no passing trial |
| max_amp | output | AMP_W | Largest passing amplitude |

## Verification
The first amplitude is due at the falling edge after the rising edge that samples `start`. Every later trial begins exactly `recover_len`+`gate_len`+4 cycles after the one before. The result, `done` and `no_pass` are due on the first cycle in which `busy` is low. The bench drives and samples only at falling edges and numbers each busy cycle from the start edge. At each trial boundary it compares `amp_code` with an amplitude list computed from the requirements. It then checks the total busy length and the result at the cycle where they fall due. Error injection is either a function of the amplitude or a constant level during the whole trial. Constant injection with a long recovery wait shows whether recovery pulses, the threshold boundary and the count saturation change the outcome.

// File: rtl/jtol_pkg.sv
package jtol_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_SET     = 3'd1,
        S_RECOVER = 3'd2,
        S_MEASURE = 3'd3,
        S_DECIDE  = 3'd4,
        S_FINISH  = 3'd5
    } jtol_state_e;
endpackage

// File: rtl/jtol_timer.sv
module jtol_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R5: a spent timer stays spent until reloaded
    p_timer_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/jtol_errcnt.sv
module jtol_errcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_err_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP && inc_i && !clr_i) |=> (cnt_o == TOP));

    p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/jtol_step.sv
module jtol_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] amp_i,
    input  logic [W-1:0] step_i,
    input  logic [W-1:0] res_i,
    input  logic         pass_i,
    output logic [W-1:0] next_amp_o,
    output logic [W-1:0] next_step_o,
    output logic         last_o
);
    logic [W-1:0] half;
    logic [W:0]   sum;
    logic [W-1:0] up_amp, dn_amp;

    always_comb begin
        half        = step_i >> 1;
        sum         = {1'b0, amp_i} + {1'b0, half};
        up_amp      = sum[W] ? {W{1'b1}} : sum[W-1:0];
        dn_amp      = (half > amp_i) ? '0 : (amp_i - half);
        next_amp_o  = pass_i ? up_amp : dn_amp;
        next_step_o = half;
        last_o      = (step_i <= res_i) || (half == '0);
    end
endmodule

// File: rtl/jtol_search.sv
module jtol_search
    import jtol_pkg::*;
#(
    parameter int AMP_W = 8,
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AMP_W-1:0] tol_limit,
    input  logic [AMP_W-1:0] resolution,
    input  logic [CNT_W-1:0] recover_len,
    input  logic [CNT_W-1:0] gate_len,
    input  logic [ERR_W-1:0] err_limit,
    input  logic             err_pulse,
    output logic [AMP_W-1:0] amp_code,
    output logic             busy,
    output logic             done,
    output logic             no_pass,
    output logic [AMP_W-1:0] max_amp
);
    typedef struct packed {
        jtol_state_e      state;
        logic [AMP_W-1:0] amp;
        logic [AMP_W-1:0] step;
        logic [AMP_W-1:0] best;
        logic             passed;
        logic [AMP_W-1:0] res;
        logic [CNT_W-1:0] rec;
        logic [CNT_W-1:0] gate;
        logic [ERR_W-1:0] thr;
    } regs_t;

    regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             ec_clr;
    logic             ec_inc;
    logic [ERR_W-1:0] ec_cnt;
    logic             trial_pass;
    logic [AMP_W-1:0] nx_amp;
    logic [AMP_W-1:0] nx_step;
    logic             nx_last;

    jtol_timer #(.W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    jtol_errcnt #(.W(ERR_W)) u_errcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ec_clr),
        .inc_i (ec_inc),
        .cnt_o (ec_cnt)
    );

    jtol_step #(.W(AMP_W)) u_step (
        .amp_i       (r_q.amp),
        .step_i      (r_q.step),
        .res_i       (r_q.res),
        .pass_i      (trial_pass),
        .next_amp_o  (nx_amp),
        .next_step_o (nx_step),
        .last_o      (nx_last)
    );

    assign trial_pass = (ec_cnt <= r_q.thr);
    assign ec_inc     = (r_q.state == S_MEASURE) && err_pulse;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ec_clr   = 1'b0;
        case (r_q.state)
            S_IDLE, S_FINISH: begin
                if (start) begin
                    r_d.amp    = tol_limit >> 1;
                    r_d.step   = tol_limit >> 1;
                    r_d.best   = '0;
                    r_d.passed = 1'b0;
                    r_d.res    = resolution;
                    r_d.rec    = recover_len;
                    r_d.gate   = gate_len;
                    r_d.thr    = err_limit;
                    r_d.state  = S_SET;
                end
            end
            S_SET: begin
                tmr_load  = 1'b1;
                tmr_val   = r_q.rec;
                r_d.state = S_RECOVER;
            end
            S_RECOVER: begin
                if (tmr_zero) begin
                    tmr_load  = 1'b1;
                    tmr_val   = r_q.gate;
                    ec_clr    = 1'b1;
                    r_d.state = S_MEASURE;
                end
            end
            S_MEASURE: begin
                if (tmr_zero)
                    r_d.state = S_DECIDE;
            end
            S_DECIDE: begin
                if (trial_pass) begin
                    r_d.best   = r_q.amp;
                    r_d.passed = 1'b1;
                end
                if (nx_last) begin
                    r_d.state = S_FINISH;
                end else begin
                    r_d.amp   = nx_amp;
                    r_d.step  = nx_step;
                    r_d.state = S_SET;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != S_IDLE) && (r_q.state != S_FINISH);
    assign done     = (r_q.state == S_FINISH);
    assign no_pass  = done && !r_q.passed;
    assign max_amp  = r_q.best;
    assign amp_code = busy ? r_q.amp : '0;

    // R4: the decision step either begins a new trial or ends the search
    p_decide_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_DECIDE) |=> (r_q.state == S_SET || r_q.state == S_FINISH));

    // R5: the amplitude holds while the device settles and errors are counted
    p_amp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_RECOVER || r_q.state == S_MEASURE) |=> $stable(amp_code));

    p_nopass_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        no_pass |-> (max_amp == '0 && done));

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_RECOVER && !tmr_zero && start) |=> (r_q.state == S_RECOVER));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/jtol_search_bench.sv
module jtol_search_bench;
    localparam int AMP_W = 8;
    localparam int CNT_W = 16;
    localparam int ERR_W = 8;
    localparam int ERR_TOP = (1 << ERR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [AMP_W-1:0] tol_limit = '0;
    logic [AMP_W-1:0] resolution = '0;
    logic [CNT_W-1:0] recover_len = '0;
    logic [CNT_W-1:0] gate_len = '0;
    logic [ERR_W-1:0] err_limit = '0;
    logic             err_pulse;
    logic [AMP_W-1:0] amp_code;
    logic             busy, done, no_pass;
    logic [AMP_W-1:0] max_amp;

    logic             err_all = 1'b0;
    logic [AMP_W-1:0] dev_lim = '0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    assign err_pulse = err_all ? 1'b1 : (amp_code > dev_lim);

    jtol_search #(.AMP_W(AMP_W), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_jtol_search (
        .clk(clk), .rst_n(rst_n), .start(start), .tol_limit(tol_limit),
        .resolution(resolution), .recover_len(recover_len), .gate_len(gate_len),
        .err_limit(err_limit), .err_pulse(err_pulse), .amp_code(amp_code),
        .busy(busy), .done(done), .no_pass(no_pass), .max_amp(max_amp)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_search(input string tag, input int tol, input int res, input int lim,
                              input int rec, input int gate, input int thr, input bit all_err,
                              input bit poke_start);
        int m_amp[16];
        int m_n, amp, step, best, half, per, idx, cnt, ka;
        bit passed, pass, last;
        // expected sequence from R2, R3, R4, R7, R8
        amp = tol / 2; step = tol / 2; best = 0; passed = 0; m_n = 0;
        forever begin
            m_amp[m_n] = amp; m_n++;
            cnt  = (gate + 1 > ERR_TOP) ? ERR_TOP : gate + 1;
            pass = all_err ? (cnt <= thr) : (amp <= lim);
            if (pass) begin best = amp; passed = 1; end
            half = step / 2;
            last = (step <= res) || (half == 0);
            if (last || m_n == 16) break;
            amp = pass ? ((amp + half > 255) ? 255 : amp + half)
                       : ((half > amp) ? 0 : amp - half);
            step = half;
        end
        per = rec + gate + 4;

        @(negedge clk);
        tol_limit = tol[AMP_W-1:0]; resolution = res[AMP_W-1:0];
        recover_len = rec[CNT_W-1:0]; gate_len = gate[CNT_W-1:0];
        err_limit = thr[ERR_W-1:0]; dev_lim = lim[AMP_W-1:0]; err_all = all_err;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
        idx = 0; ka = 0;
        while (busy && idx < 100000) begin
            if (idx % per == 0 && ka < m_n) begin
                check(amp_code == m_amp[ka][AMP_W-1:0], {tag, " R3 trial amplitude"},
                      amp_code, m_amp[ka]);
                ka++;
            end
            if (poke_start && idx == 3) begin start = 1'b1; tol_limit = 8'd30; end
            if (poke_start && idx == 4) start = 1'b0;
            idx++;
            @(negedge clk);
        end
        check(ka == m_n, {tag, " R4 trial count"}, ka, m_n);
        check(idx == m_n * per, {tag, " R5 busy length"}, idx, m_n * per);
        check(done == 1'b1, {tag, " R9 done"}, done, 1);
        check(max_amp == best[AMP_W-1:0], {tag, " R9 result"}, max_amp, best);
        check(no_pass == !passed, {tag, " R10 no_pass"}, no_pass, !passed);
        check(amp_code == '0, {tag, " R12 amp idle"}, amp_code, 0);
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, {tag, " R9 done held"}, done, 1);
    endtask

    task automatic t_reset;
        check(amp_code == '0, "R1 amp_code", amp_code, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(no_pass == 1'b0, "R1 no_pass", no_pass, 0);
        check(max_amp == '0, "R1 max_amp", max_amp, 0);
    endtask

    task automatic t_basic;
        run_search("basic", 200, 1, 73, 3, 4, 1, 1'b0, 1'b0);
    endtask

    task automatic t_coarse;
        run_search("coarse", 255, 8, 250, 2, 2, 0, 1'b0, 1'b0);
    endtask

    task automatic t_tiny;
        run_search("tiny", 2, 0, 0, 1, 1, 0, 1'b0, 1'b0);
    endtask

    task automatic t_all_fail;
        run_search("allfail_R7", 120, 2, 0, 20, 5, 5, 1'b1, 1'b0);
    endtask

    task automatic t_edge_pass;
        // R6: 21 recovery cycles of pulses would push the count above 6
        run_search("edgepass_R6", 120, 2, 0, 20, 5, 6, 1'b1, 1'b0);
    endtask

    task automatic t_saturate;
        // R8: 260 pulses; saturated 255 > 254 fails, a wrapped 4 would pass
        run_search("sat_R8", 100, 4, 0, 2, 259, 254, 1'b1, 1'b0);
    endtask

    task automatic t_busy_start;
        run_search("busystart_R11", 180, 1, 111, 4, 3, 0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_coarse();
        t_tiny();
        t_all_fail();
        t_edge_pass();
        t_saturate();
        t_busy_start();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R5 actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule